// File: doc/BRIEF.md
# Serial Peripheral Slave with Packet-Ready Interrupt

This block is the serial front end of a controller that answers a host over a four-wire synchronous serial bus. The host owns the serial clock, and the block only ever responds as a slave. Internal logic places response or report packets into a small transmit queue. Each queue entry is a byte plus a flag that marks the byte that closes a packet. The block shifts those bytes out to the host. At the same time it assembles the command bytes the host shifts in and hands each finished one to internal logic as a one-cycle valid pulse.

The serial clock, data input and active-low select are brought into the system clock domain through a parameterised synchronizer chain. All edge detection is done there, so the serial clock must run at no more than a quarter of the system clock. A level interrupt tells the host that a complete packet is waiting. It drops as soon as the first byte of that packet has left. The serial output is driven only while the block is selected, so other slaves can share the line.

Top module: `spi_irq_slave`

## Requirements
- R1: After reset, irq_o is 0, sdo_oe_o is 0, rx_valid_o is 0 and wr_ready_o is 1.
- R2: sdo_oe_o is 1 only while ss_n_i is low. sdo_o is high impedance otherwise. Both follow ss_n_i within a few system clocks.
- R3: Bytes go out MSB first. The first bit is on sdo_o before the first rising sck_i edge after selection. sdo_o changes only after a falling sck_i edge and holds steady while sck_i is high.
- R4: Bytes on sdi_i are sampled on rising sck_i edges, MSB first. rx_valid_o pulses for one cycle with the byte in rx_data_o after the eighth rising edge.
- R5: If the queue is empty when a byte begins, the block sends 0x00 and removes nothing from the queue.
- R6: irq_o goes to 1 when a byte written with wr_last_i = 1 completes a packet in the queue. Bytes of a packet that is not yet closed do not raise it.
- R7: irq_o goes to 0 once all eight bits of the first byte of the pending packet have been clocked out.
- R8: irq_o stays 0 until the closing byte of the packet being read has been sent. It then goes to 1 again only if another complete packet is queued.
- R9: Raising ss_n_i in the middle of a byte discards that byte. No rx_valid_o pulse occurs, the bit position returns to zero, and the transmit byte is not consumed, so it is sent again on the next selection.
- R10: wr_ready_o is 0 while the queue holds FIFO_DEPTH bytes. A write while it is 0 is ignored.
- R11: If a byte that closes a new packet is written in the same cycle that the closing byte of the current packet leaves, both events are counted, and irq_o is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host, idle low |
| sdi_i | input | 1 | Serial data from host |
| ss_n_i | input | 1 | Slave select, low = selected |
| sdo_o | output | 1 | Serial data to host, high impedance when deselected |
| sdo_oe_o | output | 1 | High while sdo_o is driven |
| irq_o | output | 1 | Level interrupt: a complete packet is waiting |
| wr_valid_i | input | 1 | Queue write strobe |
| wr_data_i | input | 8 | Byte to queue |
| wr_last_i | input | 1 | Byte closes its packet |
| wr_ready_o | output | 1 | Queue has room |
| rx_valid_o | output | 1 | One-cycle pulse: received byte valid |
| rx_data_o | output | 8 | Received byte |

## Verification
Two functions can coincide in one cycle: a queue write of a byte that closes a new packet, and the removal of the closing byte of the packet the host is reading. Both change the count of complete packets, in opposite directions. The bench creates this by counting the synchronizer stages from its own sck_i rise on the last bit of the host's read. It holds the closing write exactly across the clock edge where the eighth rising edge is acted on. Afterwards irq_o must be 1 and the new packet must read back intact. A design that drops either event shows a low interrupt or a wrong byte sequence.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   // one queue slot: payload plus end-of-packet marker
   typedef struct packed {
      logic  last;
      byte_t data;
   } q_word_t;

endpackage

// File: rtl/spi_irq_sync.sv
module spi_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic sdi_i,
   input  logic ss_n_i,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic sdi_o,
   output logic sel_o,
   output logic sel_rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_irq_sync: STAGES must be at least 2");
   end

   // index STAGES-1 is the synchronized value, index STAGES the prior one
   logic [STAGES:0] sck_pipe;
   logic [STAGES:0] ss_pipe;
   logic [STAGES-1:0] sdi_pipe;

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_pipe[g] <= 1'b0;
            ss_pipe[g]  <= 1'b1;
         end else if (g == 0) begin
            sck_pipe[g] <= sck_i;
            ss_pipe[g]  <= ss_n_i;
         end else begin
            sck_pipe[g] <= sck_pipe[g-1];
            ss_pipe[g]  <= ss_pipe[g-1];
         end
      end
      if (g < STAGES) begin : g_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sdi_pipe[g] <= 1'b0;
            else if (g == 0) sdi_pipe[g] <= sdi_i;
            else             sdi_pipe[g] <= sdi_pipe[g-1];
         end
      end
   end

   assign sck_rise_o = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
   assign sck_fall_o = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
   assign sdi_o      = sdi_pipe[STAGES-1];
   assign sel_o      = ~ss_pipe[STAGES-1];
   assign sel_rise_o = ~ss_pipe[STAGES-1] & ss_pipe[STAGES];

endmodule

// File: rtl/spi_irq_fifo.sv
module spi_irq_fifo
   import spi_irq_pkg::*;
#(
   parameter  int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  q_word_t          push_word_i,
   input  logic             pop_i,
   output q_word_t          head_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CNT_W-1:0] count_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_irq_fifo: DEPTH must be at least 2");
   end

   q_word_t          slots [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;

   function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) slots[wr_ptr] <= push_word_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= ptr_step(wr_ptr);
         if (pop_i)  rd_ptr <= ptr_step(rd_ptr);
         case ({push_i, pop_i})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_o  = slots[rd_ptr];
   assign empty_o = (count == '0);
   assign full_o  = (count == CNT_W'(DEPTH));
   assign count_o = count;

endmodule

// File: rtl/spi_irq_shifter.sv
module spi_irq_shifter
   import spi_irq_pkg::*;
#(
   parameter byte_t IDLE_BYTE = 8'h00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sck_rise_i,
   input  logic                 sck_fall_i,
   input  logic                 sdi_i,
   input  logic                 sel_i,
   input  logic                 sel_rise_i,
   input  byte_t                head_data_i,
   input  logic                 head_valid_i,
   output logic                 sdo_o,
   output logic                 oe_o,
   output logic                 pop_o,
   output logic                 rx_valid_o,
   output byte_t                rx_data_o,
   output logic [BIT_CNT_W-1:0] bit_cnt_o
);

   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

   byte_t                tx_sh;
   byte_t                rx_sh;
   logic                 tx_from_q;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic                 byte_done;

   assign byte_done = sel_i && !sel_rise_i && sck_rise_i && (bit_cnt == LAST_BIT);
   // a queued byte leaves the queue only once all its bits went out
   assign pop_o     = byte_done && tx_from_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh      <= IDLE_BYTE;
         rx_sh      <= '0;
         tx_from_q  <= 1'b0;
         bit_cnt    <= '0;
         oe_o       <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_data_o  <= '0;
      end else begin
         oe_o       <= sel_i;
         rx_valid_o <= byte_done;
         if (!sel_i) begin
            bit_cnt   <= '0;
            tx_from_q <= 1'b0;
         end else if (sel_rise_i) begin
            tx_sh     <= head_valid_i ? head_data_i : IDLE_BYTE;
            tx_from_q <= head_valid_i;
            bit_cnt   <= '0;
         end else if (sck_rise_i) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sdi_i};
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) rx_data_o <= {rx_sh[BYTE_W-2:0], sdi_i};
         end else if (sck_fall_i) begin
            if (bit_cnt == '0) begin
               tx_sh     <= head_valid_i ? head_data_i : IDLE_BYTE;
               tx_from_q <= head_valid_i;
            end else begin
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sdo_o     = tx_sh[BYTE_W-1];
   assign bit_cnt_o = bit_cnt;

endmodule

// File: rtl/spi_irq_intr.sv
module spi_irq_intr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close_push_i,
   input  logic             pop_i,
   input  logic             pop_last_i,
   output logic             irq_o,
   output logic [CNT_W-1:0] pkt_cnt_o
);

   logic [CNT_W-1:0] pkt_cnt;
   logic [CNT_W-1:0] pkt_nxt;
   logic             reading;
   logic             reading_nxt;
   logic             close_pop;

   assign close_pop = pop_i && pop_last_i;

   always_comb begin
      pkt_nxt = pkt_cnt;
      if (close_push_i && !close_pop)      pkt_nxt = pkt_cnt + 1'b1;
      else if (!close_push_i && close_pop) pkt_nxt = pkt_cnt - 1'b1;
      reading_nxt = pop_i ? !pop_last_i : reading;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_cnt <= '0;
         reading <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         pkt_cnt <= pkt_nxt;
         reading <= reading_nxt;
         irq_o   <= (pkt_nxt != '0) && !reading_nxt;
      end
   end

   assign pkt_cnt_o = pkt_cnt;

endmodule

// File: rtl/spi_irq_slave.sv
module spi_irq_slave
   import spi_irq_pkg::*;
#(
   parameter  int unsigned FIFO_DEPTH  = 8,
   parameter  int unsigned SYNC_STAGES = 2,
   parameter  byte_t       IDLE_BYTE   = 8'h00,
   localparam int unsigned CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       sdi_i,
   input  logic       ss_n_i,
   output logic       sdo_o,
   output logic       sdo_oe_o,
   output logic       irq_o,
   input  logic       wr_valid_i,
   input  logic [7:0] wr_data_i,
   input  logic       wr_last_i,
   output logic       wr_ready_o,
   output logic       rx_valid_o,
   output logic [7:0] rx_data_o
);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("spi_irq_slave: FIFO_DEPTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_irq_slave: SYNC_STAGES must be at least 2");
   end

   logic                 sck_rise, sck_fall, sdi_s, sel, sel_rise;
   logic                 push, pop, fifo_empty, fifo_full;
   logic [CNT_W-1:0]     fifo_cnt, pkt_cnt;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic                 sdo_bit;
   q_word_t              head;
   q_word_t              push_word;

   spi_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i), .ss_n_i(ss_n_i),
      .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sdi_o(sdi_s),
      .sel_o(sel), .sel_rise_o(sel_rise)
   );

   assign push       = wr_valid_i && !fifo_full;
   assign push_word  = '{last: wr_last_i, data: wr_data_i};
   assign wr_ready_o = !fifo_full;

   spi_irq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_word_i(push_word),
      .pop_i(pop), .head_o(head), .empty_o(fifo_empty), .full_o(fifo_full),
      .count_o(fifo_cnt)
   );

   spi_irq_shifter #(.IDLE_BYTE(IDLE_BYTE)) u_shift (
      .clk(clk), .rst_n(rst_n), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
      .sdi_i(sdi_s), .sel_i(sel), .sel_rise_i(sel_rise),
      .head_data_i(head.data), .head_valid_i(!fifo_empty),
      .sdo_o(sdo_bit), .oe_o(sdo_oe_o), .pop_o(pop),
      .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .bit_cnt_o(bit_cnt)
   );

   spi_irq_intr #(.CNT_W(CNT_W)) u_intr (
      .clk(clk), .rst_n(rst_n), .close_push_i(push && wr_last_i),
      .pop_i(pop), .pop_last_i(head.last), .irq_o(irq_o), .pkt_cnt_o(pkt_cnt)
   );

   assign sdo_o = sdo_oe_o ? sdo_bit : 1'bz;

endmodule

// File: rtl/spi_irq_slave_chk.sv
module spi_irq_slave_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4,
   parameter int unsigned BC_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             sdo_oe,
   input logic             rx_valid,
   input logic             pop,
   input logic             fifo_empty,
   input logic [CNT_W-1:0] fifo_cnt,
   input logic [CNT_W-1:0] pkt_cnt,
   input logic             irq,
   input logic [BC_W-1:0]  bit_cnt,
   input logic             wr_valid,
   input logic             wr_ready
);

   // R4: received-byte strobe never lasts two cycles
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R2: output enable trails the synchronized select by one register
   a_r2_oe_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe == $past(sel));

   // R5: nothing leaves an empty queue
   a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty);

   // R10: occupancy never exceeds the depth
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(DEPTH));

   // R10: a refused write leaves the occupancy alone
   a_r10_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !pop) |=> $stable(fifo_cnt));

   // R6: interrupt only with a complete packet queued
   a_r6_irq_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pkt_cnt != '0));

   // R9: deselection clears the bit position
   a_r9_bitpos_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (bit_cnt == '0));

endmodule

bind spi_irq_slave spi_irq_slave_chk #(
   .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .BC_W(spi_irq_pkg::BIT_CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .sdo_oe(sdo_oe_o), .rx_valid(rx_valid_o),
   .pop(pop), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt), .pkt_cnt(pkt_cnt),
   .irq(irq_o), .bit_cnt(bit_cnt), .wr_valid(wr_valid_i), .wr_ready(wr_ready_o)
);

// File: tb/sim_spi_irq_slave.sv
module sim_spi_irq_slave;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, sdi = 1'b0, ss_n = 1'b1;
   logic       sdo, sdo_oe, irq;
   logic       wr_valid = 1'b0, wr_last = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_ready, rx_valid;
   logic [7:0] rx_data;

   int n_checks = 0;
   int n_fail   = 0;
   int rx_count = 0;
   int sdo_glitch = 0;
   logic [7:0] rx_seen = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_irq_slave #(.FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .ss_n_i(ss_n),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_o(irq),
      .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_last_i(wr_last),
      .wr_ready_o(wr_ready), .rx_valid_o(rx_valid), .rx_data_o(rx_data)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_count = rx_count + 1;
         rx_seen  = rx_data;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic queue_byte(input logic [7:0] d, input logic last);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d; wr_last = last;
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
   endtask

   task automatic select_on;
      ss_n = 1'b0;
      wait_n(6);
   endtask

   task automatic select_off;
      ss_n = 1'b1;
      wait_n(6);
   endtask

   // one host byte; optionally hold a closing write across the edge
   // where the slave acts on the eighth rising clock edge
   task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso,
                       input bit inj, input logic [7:0] inj_data);
      logic [7:0] got;
      logic       b;
      for (int i = 7; i >= 0; i--) begin
         sdi = mosi[i];
         wait_n(4);
         b = sdo;
         got[i] = b;
         sck = 1'b1;
         if (inj && i == 0) begin
            wait_n(2);
            wr_valid = 1'b1; wr_data = inj_data; wr_last = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0; wr_last = 1'b0;
            @(negedge clk);
         end else begin
            wait_n(4);
         end
         if (sdo !== b) sdo_glitch++;
         sck = 1'b0;
      end
      wait_n(4);
      miso = got;
   endtask

   task automatic partial(input int nbits);
      for (int i = 0; i < nbits; i++) begin
         sdi = 1'b1;
         wait_n(4);
         sck = 1'b1;
         wait_n(4);
         sck = 1'b0;
      end
      wait_n(4);
   endtask

   task automatic t_reset;
      check("R1 irq", irq, 1'b0);
      check("R1 oe", sdo_oe, 1'b0);
      check("R1 rx_valid", rx_valid, 1'b0);
      check("R1 wr_ready", wr_ready, 1'b1);
   endtask

   task automatic t_select;
      check("R2 oe idle", sdo_oe, 1'b0);
      select_on();
      check("R2 oe selected", sdo_oe, 1'b1);
      select_off();
      check("R2 oe released", sdo_oe, 1'b0);
   endtask

   task automatic t_empty;
      logic [7:0] m;
      int c0;
      c0 = rx_count;
      select_on();
      xfer(8'hA5, m, 1'b0, 8'h00);
      select_off();
      check("R5 idle byte", m, 8'h00);
      check("R4 rx count", rx_count, c0 + 1);
      check("R4 rx data", rx_seen, 8'hA5);
      check("R5 irq quiet", irq, 1'b0);
   endtask

   task automatic t_packet;
      logic [7:0] m;
      queue_byte(8'h81, 1'b0);
      queue_byte(8'h42, 1'b0);
      wait_n(2);
      check("R6 open packet no irq", irq, 1'b0);
      queue_byte(8'h3C, 1'b1);
      wait_n(2);
      check("R6 irq on close", irq, 1'b1);
      select_on();
      xfer(8'h5A, m, 1'b0, 8'h00);
      check("R3 first byte", m, 8'h81);
      check("R7 irq after first", irq, 1'b0);
      check("R4 rx data 5A", rx_seen, 8'h5A);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R3 second byte", m, 8'h42);
      check("R8 irq mid packet", irq, 1'b0);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R3 third byte", m, 8'h3C);
      check("R8 irq after close", irq, 1'b0);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R5 drained", m, 8'h00);
      select_off();
      check("R3 sdo steady while sck high", sdo_glitch, 0);
   endtask

   task automatic t_two_packets;
      logic [7:0] m;
      queue_byte(8'h61, 1'b0);
      queue_byte(8'h62, 1'b1);
      queue_byte(8'h71, 1'b1);
      wait_n(2);
      check("R6 irq two packets", irq, 1'b1);
      select_on();
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R7 irq low in first", irq, 1'b0);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R8 byte 62", m, 8'h62);
      check("R8 irq back for next", irq, 1'b1);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R8 byte 71", m, 8'h71);
      check("R7 irq low at end", irq, 1'b0);
      select_off();
   endtask

   task automatic t_abort;
      logic [7:0] m;
      int c0;
      queue_byte(8'hC3, 1'b1);
      wait_n(2);
      c0 = rx_count;
      select_on();
      partial(4);
      select_off();
      check("R9 no rx strobe", rx_count, c0);
      check("R9 irq kept", irq, 1'b1);
      select_on();
      xfer(8'h96, m, 1'b0, 8'h00);
      select_off();
      check("R9 byte resent", m, 8'hC3);
      check("R9 rx realigned", rx_seen, 8'h96);
      check("R9 irq cleared", irq, 1'b0);
   endtask

   task automatic t_full;
      logic [7:0] m;
      for (int i = 0; i < DEPTH; i++) queue_byte(8'h10 + 8'(i), (i == DEPTH - 1));
      wait_n(1);
      check("R10 ready low when full", wr_ready, 1'b0);
      queue_byte(8'hEE, 1'b1);
      select_on();
      for (int i = 0; i < DEPTH; i++) begin
         xfer(8'h00, m, 1'b0, 8'h00);
         check("R10 stored byte", m, 8'h10 + 8'(i));
      end
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R10 extra write dropped", m, 8'h00);
      select_off();
      check("R10 ready again", wr_ready, 1'b1);
   endtask

   task automatic t_same_cycle;
      logic [7:0] m;
      queue_byte(8'h11, 1'b1);
      queue_byte(8'h22, 1'b0);
      wait_n(2);
      check("R11 irq before", irq, 1'b1);
      select_on();
      xfer(8'h00, m, 1'b1, 8'h33);
      check("R11 byte 11", m, 8'h11);
      check("R11 irq after clash", irq, 1'b1);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R11 byte 22", m, 8'h22);
      check("R11 irq low reading", irq, 1'b0);
      xfer(8'h00, m, 1'b0, 8'h00);
      check("R11 byte 33", m, 8'h33);
      check("R11 irq low drained", irq, 1'b0);
      select_off();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      t_reset();
      rst_n = 1'b1;
      wait_n(3);
      t_reset();
      t_select();
      t_empty();
      t_packet();
      t_two_packets();
      t_abort();
      t_full();
      t_same_cycle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule